// File: doc/BRIEF.md
# Command Packet Taskfile Executor

This block runs the register phase of a disk command that software has left in memory as a packed command packet. A single start pulse, together with the packet's base address, makes the engine read the packet header through a byte-wide memory read port. It checks the control flags and keeps the two chain pointers and the length field. It then walks the list of register pairs that follows the header. Each pair is a data byte followed by an address byte. Every pair that is not marked as padding becomes one write strobe on the device register interface, issued in list order.

The list ends at the pair whose address byte carries the end mark. It is also cut short when it runs past the size the length byte declares. When the walk is over, the engine writes a response code into the first byte of the packet through the memory write port. It then pulses `done` for one cycle, together with an error flag and an optional interrupt request. The data transfer that may follow is handled elsewhere. This block only hands over the scatter-gather pointer and the data-phase flag.

Top module: `cbx_exec`

## Requirements
- R1: While reset is asserted and after it is released with no start pulse, `busy`, `done`, `err`, `irq`, `reg_wr_en`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: After a run, `next_ptr` holds packet bytes 4..7 and `sg_ptr` holds bytes 8..11, both little-endian (lowest address is the least significant byte). `data_phase` equals bit 2 of packet byte 2.
- R3: Register pairs start at packet byte 16, each a data byte at the even offset followed by an address byte. Each executed pair gives exactly one `reg_wr_en` cycle with `reg_addr` = address byte bits 4:0 and `reg_wr_data` = the data byte, in list order.
- R4: A pair whose address byte has bit 5 set issues no register write.
- R5: A pair whose address byte has bit 7 set is the last one. It is still executed unless bit 5 is set, and no memory byte after it is read.
- R6: When a list ends on its end mark, the value 0x01 is written to packet byte 0 and `done` pulses with `err` = 0.
- R7: If bit 0 of packet byte 2 is clear, no register write is issued, 0xFE is written to packet byte 0, and `done` pulses with `err` = 1.
- R8: With L the value of packet byte 3, at most 4*L+2 pairs are read. A list holding that many pairs with no end mark stops without reading a further pair. 0xC0 is written to byte 0 and `done` pulses with `err` = 1. The pairs before the stop are still written. A list that ends exactly on pair 4*L+2 succeeds.
- R9: `irq` pulses with `done` exactly when bit 3 of packet byte 2 is set.
- R10: A start pulse while `busy` is 1 is ignored: no second response is written and the running packet completes unchanged.
- R11: `done` lasts exactly one cycle, and `err` is 1 only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the packet at `base_addr` |
| base_addr | input | AW | Byte address of the packet |
| busy | output | 1 | Engine is running a packet |
| mem_rd_en | output | 1 | Memory byte read request; data is returned one cycle later |
| mem_wr_en | output | 1 | Memory byte write strobe (response byte) |
| mem_addr | output | AW | Byte address for a read or a write |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_data | output | 8 | Response code to write |
| reg_wr_en | output | 1 | Device register write strobe |
| reg_addr | output | RA_W | Device register address |
| reg_wr_data | output | 8 | Device register write data |
| next_ptr | output | AW | Next-packet pointer from the header |
| sg_ptr | output | AW | Scatter-gather list pointer from the header |
| data_phase | output | 1 | A data transfer follows this packet |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The completed packet failed |
| irq | output | 1 | Interrupt request, pulsed with `done` |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit length field and a 5-bit register address. A length byte of 0 sets the pair limit to two. This makes both sides of the length boundary reachable in a few dozen cycles: one packet overruns at the third pair and another ends exactly on the second. A full eight-pair command list with a padding pair sits under a limit of ten. With the 5-bit register address, the padding and end marks sit outside the address field. The bench can therefore tell a skipped pair from a written one at the register port.

// File: rtl/cbx_pkg.sv
`timescale 1ns/1ps
package cbx_pkg;
  // fixed packet layout: neighbours decode these offsets and bits
  localparam int OFF_CTRL     = 2;
  localparam int OFF_LEN      = 3;
  localparam int OFF_NEXT     = 4;
  localparam int OFF_SG       = 8;
  localparam int OFF_HDR_LAST = 11;
  localparam int OFF_LIST     = 16;

  localparam int FLAG_VALID = 0;
  localparam int FLAG_DAT   = 2;
  localparam int FLAG_IEN   = 3;

  localparam int PAIR_SKIP = 5;
  localparam int PAIR_END  = 7;

  localparam logic [7:0] RSP_OK    = 8'h01;
  localparam logic [7:0] RSP_BAD   = 8'hFE;
  localparam logic [7:0] RSP_PROTO = 8'hC0;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_TAKE = 3'd2,
    S_RESP = 3'd3,
    S_FIN  = 3'd4
  } exec_state_t;
endpackage

// File: rtl/cbx_rst_sync.sv
`timescale 1ns/1ps
module cbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cbx_hdr_regs.sv
`timescale 1ns/1ps
module cbx_hdr_regs
  import cbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 8,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [OFF_W-1:0] cap_off,
  input  logic [7:0]       cap_byte,
  output logic             flag_dat,
  output logic             flag_ien,
  output logic [LEN_W-1:0] len,
  output logic [AW-1:0]    next_ptr,
  output logic [AW-1:0]    sg_ptr
);
  localparam int PB = AW / 8;

  logic hit_ctrl, hit_len;
  logic unused_cap;

  assign hit_ctrl   = cap_en && (cap_off == OFF_W'(OFF_CTRL));
  assign hit_len    = cap_en && (cap_off == OFF_W'(OFF_LEN));
  assign unused_cap = ^cap_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_dat <= 1'b0;
      flag_ien <= 1'b0;
      len      <= '0;
    end else begin
      if (hit_ctrl) begin
        flag_dat <= cap_byte[FLAG_DAT];
        flag_ien <= cap_byte[FLAG_IEN];
      end
      if (hit_len) len <= cap_byte[LEN_W-1:0];
    end
  end

  // one byte lane per pointer byte, little-endian
  for (genvar g = 0; g < PB; g++) begin : g_ptr
    logic hit_next, hit_sg;
    assign hit_next = cap_en && (cap_off == OFF_W'(OFF_NEXT + g));
    assign hit_sg   = cap_en && (cap_off == OFF_W'(OFF_SG + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        next_ptr[8*g +: 8] <= 8'h00;
        sg_ptr[8*g +: 8]   <= 8'h00;
      end else begin
        if (hit_next) next_ptr[8*g +: 8] <= cap_byte;
        if (hit_sg)   sg_ptr[8*g +: 8]   <= cap_byte;
      end
    end
  end
endmodule

// File: rtl/cbx_pair_dec.sv
`timescale 1ns/1ps
module cbx_pair_dec
  import cbx_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic [7:0]      addr_byte,
  output logic [RA_W-1:0] reg_addr,
  output logic            is_end,
  output logic            is_skip
);
  logic unused_bits;

  assign reg_addr    = addr_byte[RA_W-1:0];
  assign is_end      = addr_byte[PAIR_END];
  assign is_skip     = addr_byte[PAIR_SKIP];
  assign unused_bits = ^addr_byte;
endmodule

// File: rtl/cbx_ctrl.sv
`timescale 1ns/1ps
module cbx_ctrl
  import cbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 8,
  parameter int RA_W  = 5,
  parameter int PC_W  = LEN_W + 2,
  parameter int OFF_W = PC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [7:0]       mem_rd_data,
  input  logic [LEN_W-1:0] len,
  input  logic             flag_ien,
  input  logic [RA_W-1:0]  dec_addr,
  input  logic             dec_end,
  input  logic             dec_skip,
  output logic             hdr_cap,
  output logic [OFF_W-1:0] cur_off,
  output logic             busy,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wr_data,
  output logic             reg_wr_en,
  output logic [RA_W-1:0]  reg_addr,
  output logic [7:0]       reg_wr_data,
  output logic             done,
  output logic             err,
  output logic             irq
);
  exec_state_t      state_q, state_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic [AW-1:0]    base_q, base_d;
  logic [7:0]       rsp_q, rsp_d;
  logic [7:0]       pdata_q, pdata_d;
  logic             rwe_q, rwe_d;
  logic [RA_W-1:0]  raddr_q, raddr_d;
  logic [7:0]       rdata_q, rdata_d;

  logic [PC_W-1:0]  limit;
  logic             in_list, list_full;

  assign limit     = {len, 2'b00} + PC_W'(2);
  assign in_list   = off_q >= OFF_W'(OFF_LIST);
  assign list_full = in_list && !off_q[0] && (pcnt_q >= limit);

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    pcnt_d  = pcnt_q;
    base_d  = base_q;
    rsp_d   = rsp_q;
    pdata_d = pdata_q;
    rwe_d   = 1'b0;
    raddr_d = raddr_q;
    rdata_d = rdata_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          base_d  = base_addr;
          off_d   = OFF_W'(OFF_CTRL);
          pcnt_d  = '0;
          state_d = S_RD;
        end
      end
      S_RD: begin
        if (list_full) begin
          rsp_d   = RSP_PROTO;
          state_d = S_RESP;
        end else begin
          state_d = S_TAKE;
        end
      end
      S_TAKE: begin
        state_d = S_RD;
        if (!in_list) begin
          if (off_q == OFF_W'(OFF_CTRL) && !mem_rd_data[FLAG_VALID]) begin
            rsp_d   = RSP_BAD;
            state_d = S_RESP;
          end else if (off_q == OFF_W'(OFF_HDR_LAST)) begin
            off_d = OFF_W'(OFF_LIST);
          end else begin
            off_d = off_q + 1'b1;
          end
        end else if (!off_q[0]) begin
          pdata_d = mem_rd_data;
          off_d   = off_q + 1'b1;
        end else begin
          rwe_d   = !dec_skip;
          raddr_d = dec_addr;
          rdata_d = pdata_q;
          if (dec_end) begin
            rsp_d   = RSP_OK;
            state_d = S_RESP;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
            off_d  = off_q + 1'b1;
          end
        end
      end
      S_RESP:  state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      off_q   <= '0;
      pcnt_q  <= '0;
      base_q  <= '0;
      rsp_q   <= 8'h00;
      pdata_q <= 8'h00;
      rwe_q   <= 1'b0;
      raddr_q <= '0;
      rdata_q <= 8'h00;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      pcnt_q  <= pcnt_d;
      base_q  <= base_d;
      rsp_q   <= rsp_d;
      pdata_q <= pdata_d;
      rwe_q   <= rwe_d;
      raddr_q <= raddr_d;
      rdata_q <= rdata_d;
    end
  end

  assign hdr_cap     = (state_q == S_TAKE) && !in_list;
  assign cur_off     = off_q;
  assign busy        = state_q != S_IDLE;
  assign mem_rd_en   = (state_q == S_RD) && !list_full;
  assign mem_wr_en   = state_q == S_RESP;
  assign mem_addr    = (state_q == S_RD) ? base_q + {{(AW-OFF_W){1'b0}}, off_q} : base_q;
  assign mem_wr_data = rsp_q;
  assign reg_wr_en   = rwe_q;
  assign reg_addr    = raddr_q;
  assign reg_wr_data = rdata_q;
  assign done        = state_q == S_FIN;
  assign err         = done && (rsp_q != RSP_OK);
  assign irq         = done && flag_ien;

  AST_ERR_ONLY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_RESP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr_en)); // R6
  AST_OK_CODE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(mem_wr_data) == RSP_OK)); // R6
  AST_NO_WRITE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_data == RSP_BAD) |-> !reg_wr_en); // R7
  AST_NO_READ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || done) |-> !mem_rd_en); // R5
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en && !done)); // R1
endmodule

// File: rtl/cbx_exec.sv
`timescale 1ns/1ps
module cbx_exec
  import cbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 8,
  parameter int RA_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  output logic            busy,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_addr,
  input  logic [7:0]      mem_rd_data,
  output logic [7:0]      mem_wr_data,
  output logic            reg_wr_en,
  output logic [RA_W-1:0] reg_addr,
  output logic [7:0]      reg_wr_data,
  output logic [AW-1:0]   next_ptr,
  output logic [AW-1:0]   sg_ptr,
  output logic            data_phase,
  output logic            done,
  output logic            err,
  output logic            irq
);
  localparam int PC_W  = LEN_W + 2;
  localparam int OFF_W = PC_W + 2;

  logic             rst_sn;
  logic             hdr_cap;
  logic [OFF_W-1:0] cur_off;
  logic [LEN_W-1:0] len;
  logic             flag_ien;
  logic [RA_W-1:0]  dec_addr;
  logic             dec_end, dec_skip;

  cbx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  cbx_hdr_regs #(.AW(AW), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .cap_en   (hdr_cap),
    .cap_off  (cur_off),
    .cap_byte (mem_rd_data),
    .flag_dat (data_phase),
    .flag_ien (flag_ien),
    .len      (len),
    .next_ptr (next_ptr),
    .sg_ptr   (sg_ptr)
  );

  cbx_pair_dec #(.RA_W(RA_W)) u_dec (
    .addr_byte (mem_rd_data),
    .reg_addr  (dec_addr),
    .is_end    (dec_end),
    .is_skip   (dec_skip)
  );

  cbx_ctrl #(.AW(AW), .LEN_W(LEN_W), .RA_W(RA_W), .PC_W(PC_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start       (start),
    .base_addr   (base_addr),
    .mem_rd_data (mem_rd_data),
    .len         (len),
    .flag_ien    (flag_ien),
    .dec_addr    (dec_addr),
    .dec_end     (dec_end),
    .dec_skip    (dec_skip),
    .hdr_cap     (hdr_cap),
    .cur_off     (cur_off),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_addr    (mem_addr),
    .mem_wr_data (mem_wr_data),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .done        (done),
    .err         (err),
    .irq         (irq)
  );
endmodule

// File: tb/cbx_exec_test.sv
`timescale 1ns/1ps
module cbx_exec_test;
  localparam int AW   = 32;
  localparam int RA_W = 5;

  logic            clk, rst_n, start;
  logic [AW-1:0]   base_addr;
  logic            busy, mem_rd_en, mem_wr_en;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_rd_data, mem_wr_data;
  logic            reg_wr_en;
  logic [RA_W-1:0] reg_addr;
  logic [7:0]      reg_wr_data;
  logic [AW-1:0]   next_ptr, sg_ptr;
  logic            data_phase, done, err, irq;

  cbx_exec #(.AW(AW), .LEN_W(8), .RA_W(RA_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
    .next_ptr(next_ptr), .sg_ptr(sg_ptr), .data_phase(data_phase),
    .done(done), .err(err), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // packet image, read-only to the engine
  logic [7:0] img [0:255];
  int n_chk = 0, n_bad = 0;

  // memory read model and monitors (single writer for each log)
  int         rd_cnt = 0;
  logic [7:0] rd_last;
  int         wcnt = 0;
  logic [4:0] wl_addr [0:63];
  logic [7:0] wl_data [0:63];
  int         rsp_cnt = 0;
  logic [7:0] rsp_addr, rsp_data;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= img[mem_addr[7:0]];
      rd_last     <= mem_addr[7:0];
      rd_cnt      <= rd_cnt + 1;
    end
    if (reg_wr_en && wcnt < 64) begin
      wl_addr[wcnt] <= reg_addr;
      wl_data[wcnt] <= reg_wr_data;
      wcnt          <= wcnt + 1;
    end
    if (mem_wr_en) begin
      rsp_addr <= mem_addr[7:0];
      rsp_data <= mem_wr_data;
      rsp_cnt  <= rsp_cnt + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=%0d cycles exp=<100000", wd);
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic put_hdr(input int b, input logic [7:0] flags, input logic [7:0] len,
                         input logic [31:0] nxt, input logic [31:0] sg);
    img[b]   = 8'h00;
    img[b+1] = 8'h00;
    img[b+2] = flags;
    img[b+3] = len;
    for (int k = 0; k < 4; k++) begin
      img[b+4+k] = nxt[8*k +: 8];
      img[b+8+k] = sg[8*k +: 8];
    end
  endtask

  task automatic put_pair(input int b, input int idx, input logic [7:0] d, input logic [7:0] a);
    img[b+16+2*idx]   = d;
    img[b+16+2*idx+1] = a;
  endtask

  // run one packet, return err/irq sampled in the done cycle
  task automatic run_pkt(input int b, output logic e, output logic i);
    int cyc;
    @(negedge clk);
    base_addr = AW'(b);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk("run completes (done seen)", {31'd0, done}, 32'd1);
    e = err;
    i = irq;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    base_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {25'd0, busy, done, err, irq, reg_wr_en, mem_rd_en, mem_wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 outputs after release", {25'd0, busy, done, err, irq, reg_wr_en, mem_rd_en, mem_wr_en}, 32'd0);
  endtask

  // full command list with a padding pair, end on the command write
  task automatic t_full_list();
    logic e, i;
    int w0, r0;
    logic [4:0] ea [0:6];
    logic [7:0] ed [0:6];
    int b;
    b = 8'h20;
    clear_img();
    put_hdr(b, 8'h0D, 8'd2, 32'h1234_5678, 32'hCAFE_F00D);
    put_pair(b, 0, 8'hE0, 8'h16);
    put_pair(b, 1, 8'h08, 8'h12);
    put_pair(b, 2, 8'h11, 8'h13);
    put_pair(b, 3, 8'h22, 8'h14);
    put_pair(b, 4, 8'h33, 8'h15);
    put_pair(b, 5, 8'h00, 8'h0E);
    put_pair(b, 6, 8'h5A, 8'h20);   // padding: bit 5
    put_pair(b, 7, 8'hC8, 8'h97);   // end mark, command
    put_pair(b, 8, 8'hAA, 8'h12);   // must never be read
    ea[0]=5'h16; ed[0]=8'hE0; ea[1]=5'h12; ed[1]=8'h08;
    ea[2]=5'h13; ed[2]=8'h11; ea[3]=5'h14; ed[3]=8'h22;
    ea[4]=5'h15; ed[4]=8'h33; ea[5]=5'h0E; ed[5]=8'h00;
    ea[6]=5'h17; ed[6]=8'hC8;
    w0 = wcnt; r0 = rsp_cnt;
    run_pkt(b, e, i);
    chk("R3/R4 write count (pad skipped)", 32'(wcnt - w0), 32'd7);
    for (int k = 0; k < 7; k++) begin
      chk($sformatf("R3 write %0d address", k), {27'd0, wl_addr[w0+k]}, {27'd0, ea[k]});
      chk($sformatf("R3 write %0d data", k), {24'd0, wl_data[w0+k]}, {24'd0, ed[k]});
    end
    chk("R5 last byte read is end pair address", {24'd0, rd_last}, 32'(b + 31));
    chk("R6 one response written", 32'(rsp_cnt - r0), 32'd1);
    chk("R6 response address", {24'd0, rsp_addr}, 32'(b));
    chk("R6 response code", {24'd0, rsp_data}, 32'h01);
    chk("R6 err clear", {31'd0, e}, 32'd0);
    chk("R9 irq with ien", {31'd0, i}, 32'd1);
    chk("R2 next_ptr", next_ptr, 32'h1234_5678);
    chk("R2 sg_ptr", sg_ptr, 32'hCAFE_F00D);
    chk("R2 data_phase", {31'd0, data_phase}, 32'd1);
  endtask

  task automatic t_invalid();
    logic e, i;
    int w0, b;
    b = 8'h40;
    clear_img();
    put_hdr(b, 8'h0C, 8'd2, 32'h0, 32'h0);
    put_pair(b, 0, 8'h11, 8'h12);
    put_pair(b, 1, 8'hC8, 8'h97);
    w0 = wcnt;
    run_pkt(b, e, i);
    chk("R7 no register write", 32'(wcnt - w0), 32'd0);
    chk("R7 response code", {24'd0, rsp_data}, 32'hFE);
    chk("R7 err set", {31'd0, e}, 32'd1);
    chk("R7 no list byte read", {24'd0, rd_last}, 32'(b + 2));
  endtask

  task automatic t_overrun();
    logic e, i;
    int w0, b;
    b = 8'h60;
    clear_img();
    put_hdr(b, 8'h01, 8'd0, 32'h0, 32'h0);
    put_pair(b, 0, 8'h01, 8'h12);
    put_pair(b, 1, 8'h02, 8'h13);
    put_pair(b, 2, 8'h03, 8'h14);
    w0 = wcnt;
    run_pkt(b, e, i);
    chk("R8 pairs within limit written", 32'(wcnt - w0), 32'd2);
    chk("R8 second write address", {27'd0, wl_addr[w0+1]}, 32'h13);
    chk("R8 third pair not read", {24'd0, rd_last}, 32'(b + 19));
    chk("R8 response code", {24'd0, rsp_data}, 32'hC0);
    chk("R8 err set", {31'd0, e}, 32'd1);
  endtask

  task automatic t_end_at_limit();
    logic e, i;
    int w0, b;
    b = 8'h80;
    clear_img();
    put_hdr(b, 8'h01, 8'd0, 32'hA5A5_0001, 32'h0000_0010);
    put_pair(b, 0, 8'h07, 8'h12);
    put_pair(b, 1, 8'h25, 8'h97);
    w0 = wcnt;
    run_pkt(b, e, i);
    chk("R8 end on last allowed pair: writes", 32'(wcnt - w0), 32'd2);
    chk("R8 end on last allowed pair: code", {24'd0, rsp_data}, 32'h01);
    chk("R8 end on last allowed pair: err", {31'd0, e}, 32'd0);
    chk("R9 no irq without ien", {31'd0, i}, 32'd0);
    chk("R2 data_phase clear", {31'd0, data_phase}, 32'd0);
    chk("R2 next_ptr second packet", next_ptr, 32'hA5A5_0001);
  endtask

  task automatic t_skip_end();
    logic e, i;
    int w0, b;
    b = 8'hA0;
    clear_img();
    put_hdr(b, 8'h09, 8'd1, 32'h0, 32'h0);
    put_pair(b, 0, 8'h44, 8'h12);
    put_pair(b, 1, 8'h99, 8'hA0);   // end and skip together
    w0 = wcnt;
    run_pkt(b, e, i);
    chk("R4 skipped end pair not written", 32'(wcnt - w0), 32'd1);
    chk("R5 skipped end pair still ends list", {24'd0, rsp_data}, 32'h01);
    chk("R9 irq on ien", {31'd0, i}, 32'd1);
  endtask

  task automatic t_busy_start();
    int w0, r0, cyc, ba, bb;
    ba = 8'hC0; bb = 8'hE0;
    clear_img();
    put_hdr(ba, 8'h01, 8'd0, 32'h0, 32'h0);
    put_pair(ba, 0, 8'h31, 8'h14);
    put_pair(ba, 1, 8'h32, 8'h95);
    put_hdr(bb, 8'h01, 8'd0, 32'h0, 32'h0);
    put_pair(bb, 0, 8'h77, 8'h12);
    put_pair(bb, 1, 8'h78, 8'h97);
    w0 = wcnt; r0 = rsp_cnt;
    @(negedge clk);
    base_addr = AW'(ba);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    base_addr = AW'(bb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R11 err low on success done", {31'd0, err}, 32'd0);
    @(negedge clk);
    chk("R11 done lasts one cycle", {31'd0, done}, 32'd0);
    repeat (40) @(negedge clk);
    chk("R10 only one response", 32'(rsp_cnt - r0), 32'd1);
    chk("R10 response went to first packet", {24'd0, rsp_addr}, 32'(ba));
    chk("R10 only first packet writes", 32'(wcnt - w0), 32'd2);
    chk("R10 data of first packet", {24'd0, wl_data[w0+1]}, 32'h32);
    chk("R10 idle afterwards", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_full_list();
    t_invalid();
    t_overrun();
    t_end_at_limit();
    t_skip_end();
    t_busy_start();
    summary();
  end
endmodule